// File: doc/BRIEF.md
# Timing Receiver Lock Acquisition Sequencer

This block steps a timing-receiver endpoint from reset to a locked condition with a valid timestamp. It watches ten status qualifiers that the recovered-clock logic, the line decoder and the timestamp counter report. It walks a fixed chain of wait states, and each state waits on exactly one qualifier. It publishes a 4-bit state code and a ready flag, both registered, for a status register. It also issues single-cycle strobes that ask the clocking logic to start a phase adjustment and ask the timestamp counter to load.

The states, with their codes, are:

- START (0000): lasts one cycle and always moves to WAIT_SIG.
- WAIT_SIG (0001): waits until loss of signal is low, then moves to WAIT_FREQ.
- WAIT_FREQ (0010): frequency good moves it to WAIT_PHASE.
- WAIT_PHASE (0011): phase adjustment done moves it to WAIT_COMMA.
- WAIT_COMMA (0100): comma alignment moves it to WAIT_PKT.
- WAIT_PKT (0101): a good decoded packet moves it to WAIT_CMD.
- WAIT_CMD (0110): a received phase-adjust command moves it to WAIT_TSINIT.
- WAIT_TSINIT (0111): timestamp initialisation moves it to RUN.
- RUN (1000): the operational state.

There are three error states:

- ERR_RX (1100): receive error.
- ERR_TS (1101): timestamp check error.
- ERR_PHY (1110): physical-layer error after lock.

Besides the forward steps, the machine has these transitions:

- Loss-of-signal fallback: any state from WAIT_FREQ through RUN returns to WAIT_SIG.
- Receive-error and timestamp-error trips: these leave WAIT_PKT, WAIT_CMD, WAIT_TSINIT or RUN.
- Physical-layer trip: this leaves RUN only.
- Soft reset: from any state, a soft-reset strobe returns the machine to START.

The status qualifiers pass through a parameterised synchroniser before the machine sees them. The soft-reset strobe comes from a register write in the same clock domain and is used directly.

Top module: `tsync_bringup`

## Requirements
- R1: While rst_n is low, and on the cycle after a soft_rst strobe, state_code is 0000, ready is 0 and both strobes are 0. START always moves to 0001 on the following cycle.
- R2: Normal states advance only upward in steps of one code: 0001→0010 on sfp_los low, 0010→0011 on freq_ok, 0011→0100 on phase_done, 0100→0101 on comma_ok, 0101→0110 on pkt_ok, 0110→0111 on adj_cmd, and 0111→1000 on ts_init.
- R3: A qualifier that belongs to a later step has no effect while the machine waits on an earlier one.
- R4: sfp_los high in any state from 0010 to 1000 returns the machine to 0001. In state 0001, sfp_los high holds the machine there.
- R5: rx_err high moves states 0101 to 1000 into 1100, and has no effect below 0101.
- R6: ts_err high moves states 0101 to 1000 into 1101. When rx_err and ts_err are both high, 1100 wins.
- R7: phy_err moves the machine into 1110 only from 1000. Below 1000 it has no effect. When ts_err and phy_err are both high in 1000, 1101 wins.
- R8: States 1100, 1101 and 1110 hold against every qualifier, sfp_los included, until soft_rst.
- R9: ready is 1 exactly when state_code is 1000.
- R10: adj_req is a one-cycle pulse, coincident with the first cycle in which state_code shows 0011, once for each entry.
- R11: ts_load is a one-cycle pulse, coincident with the first cycle in which state_code shows 0111, once for each entry.
- R12: sfp_los has priority over rx_err, ts_err and phy_err in states 0010 to 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Write strobe that restarts the sequence |
| sfp_los | input | 1 | Optical loss of signal |
| freq_ok | input | 1 | Recovered frequency within range |
| phase_done | input | 1 | Phase adjustment finished |
| comma_ok | input | 1 | Comma alignment achieved |
| pkt_ok | input | 1 | Decoder produced a good packet |
| adj_cmd | input | 1 | Phase-adjust command received |
| ts_init | input | 1 | Timestamp initialised |
| rx_err | input | 1 | Receive error |
| ts_err | input | 1 | Timestamp check error |
| phy_err | input | 1 | Physical-layer error |
| state_code | output | 4 | Registered state code |
| ready | output | 1 | Timestamp valid, registered |
| adj_req | output | 1 | Phase adjustment request pulse |
| ts_load | output | 1 | Timestamp load pulse |

## Verification
Reaching the deeper states takes the whole ordered chain of qualifiers. Each directed scenario therefore first soft-resets the machine, then raises the qualifiers one at a time, waiting out the synchroniser latency after each, until it stops at a chosen state. The hardest situations sit on that chain:

- A physical-layer error that arrives before lock: the bench holds phy_err high in 0111 and then completes the chain, so the trip fires on the cycle after RUN is reached.
- Re-entry after a loss-of-signal fallback: the bench leaves every later qualifier high, so a second acquisition runs immediately. This lets it count a second adj_req pulse.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

    typedef enum logic [3:0] {
        ST_START       = 4'h0,
        ST_WAIT_SIG    = 4'h1,
        ST_WAIT_FREQ   = 4'h2,
        ST_WAIT_PHASE  = 4'h3,
        ST_WAIT_COMMA  = 4'h4,
        ST_WAIT_PKT    = 4'h5,
        ST_WAIT_CMD    = 4'h6,
        ST_WAIT_TSINIT = 4'h7,
        ST_RUN         = 4'h8,
        ST_ERR_RX      = 4'hC,
        ST_ERR_TS      = 4'hD,
        ST_ERR_PHY     = 4'hE
    } seq_state_e;

    typedef struct packed {
        logic los;
        logic freq_ok;
        logic phase_done;
        logic comma_ok;
        logic pkt_ok;
        logic adj_cmd;
        logic ts_init;
        logic rx_err;
        logic ts_err;
        logic phy_err;
    } qual_t;

    localparam int QUAL_W = $bits(qual_t);

    // loss of signal resets high: assume no light until proven otherwise
    localparam logic [QUAL_W-1:0] QUAL_RST = {1'b1, {(QUAL_W-1){1'b0}}};

endpackage

// File: rtl/tsync_qual_sync.sv
module tsync_qual_sync #(
    parameter int              WIDTH   = 10,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign dout = din;
        end else begin : g_chain
            logic [STAGES-1:0][WIDTH-1:0] stg;
            for (genvar i = 0; i < STAGES; i++) begin : g_stage
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        stg[i] <= RST_VAL;
                    end else if (i == 0) begin
                        stg[i] <= din;
                    end else begin
                        stg[i] <= stg[(i == 0) ? 0 : i-1];
                    end
                end
            end
            assign dout = stg[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/tsync_fsm.sv
module tsync_fsm
    import tsync_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  qual_t      q,
    output seq_state_e state_q,
    output seq_state_e state_d
);

    logic lock_phase;   // states WAIT_PKT and above, before errors
    assign lock_phase = (state_q == ST_WAIT_PKT) || (state_q == ST_WAIT_CMD) ||
                        (state_q == ST_WAIT_TSINIT) || (state_q == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_START;
        else        state_q <= state_d;
    end

    // next-state logic: soft reset, then loss of signal, then errors, then advance
    always_comb begin
        state_d = state_q;
        if (soft_rst) begin
            state_d = ST_START;
        end else begin
            unique case (state_q)
                ST_START:    state_d = ST_WAIT_SIG;
                ST_WAIT_SIG: if (!q.los) state_d = ST_WAIT_FREQ;
                ST_WAIT_FREQ: begin
                    if (q.los)          state_d = ST_WAIT_SIG;
                    else if (q.freq_ok) state_d = ST_WAIT_PHASE;
                end
                ST_WAIT_PHASE: begin
                    if (q.los)             state_d = ST_WAIT_SIG;
                    else if (q.phase_done) state_d = ST_WAIT_COMMA;
                end
                ST_WAIT_COMMA: begin
                    if (q.los)           state_d = ST_WAIT_SIG;
                    else if (q.comma_ok) state_d = ST_WAIT_PKT;
                end
                ST_WAIT_PKT, ST_WAIT_CMD, ST_WAIT_TSINIT, ST_RUN: begin
                    if (q.los)          state_d = ST_WAIT_SIG;
                    else if (q.rx_err)  state_d = ST_ERR_RX;
                    else if (q.ts_err)  state_d = ST_ERR_TS;
                    else if (state_q == ST_RUN) begin
                        if (q.phy_err) state_d = ST_ERR_PHY;
                    end
                    else if (state_q == ST_WAIT_PKT && q.pkt_ok)     state_d = ST_WAIT_CMD;
                    else if (state_q == ST_WAIT_CMD && q.adj_cmd)    state_d = ST_WAIT_TSINIT;
                    else if (state_q == ST_WAIT_TSINIT && q.ts_init) state_d = ST_RUN;
                end
                ST_ERR_RX, ST_ERR_TS, ST_ERR_PHY: state_d = state_q;
                default:                          state_d = ST_START;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [3:0] code_now;
    assign code_now = state_q;

    a_r1_soft_to_start: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> state_q == ST_START);

    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) && (code_now >= 4'd2) && (code_now <= 4'd8)
        |-> code_now == $past(code_now) + 4'd1);

    a_r5_rx_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR_RX) && ($past(state_q) != ST_ERR_RX)
        |-> ($past(code_now) >= 4'd5) && ($past(code_now) <= 4'd8));

    a_r7_phy_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR_PHY) && ($past(state_q) != ST_ERR_PHY)
        |-> $past(state_q) == ST_RUN);

    a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (code_now[3:2] == 2'b11) && !soft_rst |=> $stable(state_q));

    a_r3_lock_phase_known: assert property (@(posedge clk) disable iff (!rst_n)
        lock_phase |-> !$isunknown(state_d));

endmodule

// File: rtl/tsync_pulse.sv
module tsync_pulse
    import tsync_pkg::*;
#(
    parameter seq_state_e TRIG = ST_WAIT_PHASE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e state_q,
    input  seq_state_e state_d,
    output logic       pulse
);

    // registered entry detector: high on the first cycle the trigger state is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse <= 1'b0;
        else        pulse <= (state_d == TRIG) && (state_q != TRIG);
    end

    a_r10_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

    a_r10_r11_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (state_q == TRIG) && ($past(state_q) != TRIG));

endmodule

// File: rtl/tsync_bringup.sv
module tsync_bringup
    import tsync_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       sfp_los,
    input  logic       freq_ok,
    input  logic       phase_done,
    input  logic       comma_ok,
    input  logic       pkt_ok,
    input  logic       adj_cmd,
    input  logic       ts_init,
    input  logic       rx_err,
    input  logic       ts_err,
    input  logic       phy_err,
    output logic [3:0] state_code,
    output logic       ready,
    output logic       adj_req,
    output logic       ts_load
);

    qual_t      q_raw;
    qual_t      q_syn;
    seq_state_e state_q;
    seq_state_e state_d;

    assign q_raw = '{los: sfp_los, freq_ok: freq_ok, phase_done: phase_done,
                     comma_ok: comma_ok, pkt_ok: pkt_ok, adj_cmd: adj_cmd,
                     ts_init: ts_init, rx_err: rx_err, ts_err: ts_err,
                     phy_err: phy_err};

    tsync_qual_sync #(
        .WIDTH   (QUAL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (QUAL_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (q_raw),
        .dout  (q_syn)
    );

    tsync_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .q        (q_syn),
        .state_q  (state_q),
        .state_d  (state_d)
    );

    tsync_pulse #(.TRIG(ST_WAIT_PHASE)) u_adj_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .state_d (state_d),
        .pulse   (adj_req)
    );

    tsync_pulse #(.TRIG(ST_WAIT_TSINIT)) u_load_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_q (state_q),
        .state_d (state_d),
        .pulse   (ts_load)
    );

    // output process: status register copies, aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_code <= 4'h0;
            ready      <= 1'b0;
        end else begin
            state_code <= state_d;
            ready      <= (state_d == ST_RUN);
        end
    end

    a_r9_ready_code: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (state_code == 4'h8));

    a_r1_strobes_quiet_in_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == 4'h0) |-> !adj_req && !ts_load && !ready);

endmodule

// File: tb/tb_tsync_bringup.sv
`timescale 1ns/1ps
module tb_tsync_bringup;

    localparam int SETTLE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic sfp_los = 1'b1, freq_ok = 1'b0, phase_done = 1'b0, comma_ok = 1'b0;
    logic pkt_ok = 1'b0, adj_cmd = 1'b0, ts_init = 1'b0;
    logic rx_err = 1'b0, ts_err = 1'b0, phy_err = 1'b0;
    logic [3:0] state_code;
    logic ready, adj_req, ts_load;

    int tests = 0;
    int fails = 0;
    bit finished = 0;
    int adj_cnt = 0, load_cnt = 0, wide_cnt = 0;
    logic adj_prev = 1'b0, load_prev = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    tsync_bringup dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .sfp_los(sfp_los), .freq_ok(freq_ok), .phase_done(phase_done),
        .comma_ok(comma_ok), .pkt_ok(pkt_ok), .adj_cmd(adj_cmd),
        .ts_init(ts_init), .rx_err(rx_err), .ts_err(ts_err), .phy_err(phy_err),
        .state_code(state_code), .ready(ready), .adj_req(adj_req), .ts_load(ts_load)
    );

    // strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (adj_req) adj_cnt++;
        if (ts_load) load_cnt++;
        if ((adj_req && adj_prev) || (ts_load && load_prev)) wide_cnt++;
        adj_prev  = adj_req;
        load_prev = ts_load;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_code(input logic [3:0] exp, input string tag);
        tests++;
        if (state_code !== exp) begin
            fails++;
            $display("FAIL %s: state_code=%b expected %b", tag, state_code, exp);
        end
    endtask

    task automatic chk_val(input int act, input int exp, input string tag);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic clear_quals();
        sfp_los = 1'b1; freq_ok = 0; phase_done = 0; comma_ok = 0;
        pkt_ok = 0; adj_cmd = 0; ts_init = 0; rx_err = 0; ts_err = 0; phy_err = 0;
    endtask

    task automatic pulse_soft();
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
    endtask

    task automatic bring_to(input int target);
        clear_quals();
        pulse_soft();
        tick(SETTLE);
        if (target >= 2) begin sfp_los = 0;    tick(SETTLE); end
        if (target >= 3) begin freq_ok = 1;    tick(SETTLE); end
        if (target >= 4) begin phase_done = 1; tick(SETTLE); end
        if (target >= 5) begin comma_ok = 1;   tick(SETTLE); end
        if (target >= 6) begin pkt_ok = 1;     tick(SETTLE); end
        if (target >= 7) begin adj_cmd = 1;    tick(SETTLE); end
        if (target >= 8) begin ts_init = 1;    tick(SETTLE); end
    endtask

    task automatic t_reset();
        tick(2);
        chk_code(4'h0, "R1 code during reset");
        chk_val(ready, 0, "R1 ready during reset");
        chk_val(adj_req | ts_load, 0, "R1 strobes during reset");
        freq_ok = 1;
        @(negedge clk); rst_n = 1'b1;
        tick(SETTLE);
        chk_code(4'h1, "R4 held in 0001 while los high");
        chk_code(4'h1, "R3 freq_ok ignored in 0001");
        sfp_los = 0; freq_ok = 0;
        tick(SETTLE);
        pulse_soft();
        chk_code(4'h0, "R1 soft reset gives 0000");
        chk_val(ready, 0, "R1 ready low after soft reset");
        tick(1);
        chk_code(4'h1, "R1 start advances after one cycle");
    endtask

    task automatic t_bringup();
        int a0, l0;
        clear_quals();
        pulse_soft();
        a0 = adj_cnt; l0 = load_cnt;
        tick(SETTLE);
        sfp_los = 0; tick(SETTLE);
        chk_code(4'h2, "R2 0001->0010");
        comma_ok = 1; pkt_ok = 1; adj_cmd = 1; ts_init = 1; rx_err = 1; phy_err = 1;
        tick(SETTLE);
        chk_code(4'h2, "R3 later qualifiers ignored in 0010");
        chk_code(4'h2, "R5 rx_err ignored below 0101");
        comma_ok = 0; pkt_ok = 0; adj_cmd = 0; ts_init = 0; rx_err = 0; phy_err = 0;
        tick(SETTLE);
        freq_ok = 1; tick(SETTLE);
        chk_code(4'h3, "R2 0010->0011");
        chk_val(adj_cnt - a0, 1, "R10 one adj_req on entering 0011");
        chk_val(ready, 0, "R9 ready low in 0011");
        phase_done = 1; tick(SETTLE);
        chk_code(4'h4, "R2 0011->0100");
        comma_ok = 1; tick(SETTLE);
        chk_code(4'h5, "R2 0100->0101");
        pkt_ok = 1; tick(SETTLE);
        chk_code(4'h6, "R2 0101->0110");
        chk_val(load_cnt - l0, 0, "R11 no ts_load before 0111");
        adj_cmd = 1; tick(SETTLE);
        chk_code(4'h7, "R2 0110->0111");
        chk_val(load_cnt - l0, 1, "R11 one ts_load on entering 0111");
        ts_init = 1; tick(SETTLE);
        chk_code(4'h8, "R2 0111->1000");
        chk_val(ready, 1, "R9 ready high in 1000");
        chk_val(adj_cnt - a0, 1, "R10 still exactly one adj_req");
        chk_val(wide_cnt, 0, "R10 R11 strobes one cycle wide");
    endtask

    task automatic t_los();
        int a0;
        bring_to(8);
        a0 = adj_cnt;
        sfp_los = 1; rx_err = 1;
        tick(SETTLE);
        chk_code(4'h1, "R12 los beats rx_err in 1000");
        chk_val(ready, 0, "R9 ready drops with los");
        rx_err = 0; sfp_los = 0;
        tick(SETTLE * 3);
        chk_code(4'h8, "R4 reacquires after los clears");
        chk_val(adj_cnt - a0, 1, "R10 adj_req on re-entry");
        bring_to(4);
        sfp_los = 1; tick(SETTLE);
        chk_code(4'h1, "R4 los from 0100 returns to 0001");
    endtask

    task automatic t_rx_err();
        bring_to(5);
        rx_err = 1; tick(SETTLE);
        chk_code(4'hC, "R5 rx_err from 0101");
        rx_err = 0; sfp_los = 1; phy_err = 1; ts_err = 1; ts_init = 1; freq_ok = 1;
        tick(SETTLE);
        chk_code(4'hC, "R8 error state holds against qualifiers");
        clear_quals(); sfp_los = 0;
        pulse_soft();
        chk_code(4'h0, "R8 soft reset leaves error state");
        tick(SETTLE);
        chk_code(4'h2, "R1 restart after error");
    endtask

    task automatic t_priorities();
        bring_to(6);
        rx_err = 1; ts_err = 1; tick(SETTLE);
        chk_code(4'hC, "R6 rx_err beats ts_err");
        bring_to(8);
        ts_err = 1; phy_err = 1; tick(SETTLE);
        chk_code(4'hD, "R7 ts_err beats phy_err in 1000");
        sfp_los = 1; tick(SETTLE);
        chk_code(4'hD, "R8 ts error holds against los");
        bring_to(7);
        ts_err = 1; tick(SETTLE);
        chk_code(4'hD, "R6 ts_err from 0111");
    endtask

    task automatic t_phy();
        bring_to(7);
        phy_err = 1; tick(SETTLE);
        chk_code(4'h7, "R7 phy_err ignored in 0111");
        ts_init = 1; tick(SETTLE);
        chk_code(4'hE, "R7 phy_err trips after reaching 1000");
        chk_val(ready, 0, "R9 ready low in 1110");
        bring_to(8);
        phy_err = 1; tick(SETTLE);
        chk_code(4'hE, "R7 phy_err from 1000");
    endtask

    initial begin
        clear_quals();
        t_reset();
        t_bringup();
        t_los();
        t_rx_err();
        t_priorities();
        t_phy();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule